// File: doc/BRIEF.md
# SPI Master Serial Controller

This block is a register-mapped synchronous serial controller that acts as the master of an SPI link. Software programs a half-period divisor, a control word and an interrupt enable over a simple word-wide register bus. It then pushes transmit words into a FIFO and pops received words from a second FIFO. The controller generates the serial clock, drives the outgoing data line and samples the incoming one. Every frame shifted out yields one received word. Chip select is not generated here; the surrounding system drives it as a general-purpose output.

The frame width can be set from 2 to 16 bits. Clock polarity, clock phase and bit order are selectable, and an internal loopback path replaces the incoming data line. An interrupt can be raised once the transmit FIFO and the shifter are both empty, so a driver can refill in bursts of up to the FIFO depth. A soft-reset bit flushes the data path without touching the configuration. Clearing master mode releases the pins so they can be reassigned.

Top module: `spi_host_ctrl`

## Requirements
- R1: Register offsets are divisor 0x00 (16 bits, read/write), transmit data 0x04 (write pushes, reads 0), receive data 0x08, control 0x0C (14 bits, read/write), interrupt enable 0x10 (only bit 2 is stored and read back) and a mode register at 0x18 that always reads 0 and ignores writes. All registers reset to 0.
- R2: Control bits [3:0] hold the frame width minus one (field value 0 behaves as width 2). Only the low W bits of a transmit word are shifted, and received words are right-aligned with the upper bits zero.
- R3: One serial-clock half period lasts D system clocks, where D is the divisor and a divisor of 0 means 65536. A frame is loaded on the clock edge after a word is present while the engine is idle. Its 2W clock transitions occur D, 2D, ... 2W·D cycles after the load. The next frame may load one cycle after the last transition. Divisors as small as 1 operate normally.
- R4: The idle clock level equals control bit 6. With control bit 5 clear, the first data bit is driven from the load and changes after each trailing transition, and input is sampled at leading transitions. With bit 5 set, data changes at every leading transition except the first, and input is sampled at trailing transitions.
- R5: Control bit 4 set sends and assembles bits most significant first; clear sends least significant first.
- R6: With control bit 10 set, the receive shifter takes the outgoing data bit and the input pin is ignored; otherwise it takes the input pin.
- R7: The pin enables are high only while control bit 8 (master) is set; otherwise both outputs are low. Frames run only while bits 8 and 9 (enable) are both set. Clearing either aborts a running frame without producing a received word.
- R8: Each FIFO holds 8 words. A transmit write to a full FIFO is dropped. Control bits 11 and 12 clear limit the transmit and receive FIFO respectively to one word.
- R9: A read at 0x08 returns bit 17 = word valid, bit 16 = overflow flag and bits [15:0] = oldest word (0 when empty). The read pops that word and clears the overflow flag. Each completed frame pushes one word; if the receive FIFO is full, the word is dropped and the overflow flag is set.
- R10: The interrupt output is high exactly when interrupt-enable bit 2 is set, the transmit FIFO is empty and no frame is in progress.
- R11: While control bit 7 is set, both FIFOs are empty, the shifter is idle, the overflow flag is clear and transmit writes are ignored. The other registers keep their values, and operation resumes once software clears the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read (pops receive data at 0x08) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| sclk_o | output | 1 | Serial clock |
| sclk_oe | output | 1 | Serial clock drive enable |
| mosi_o | output | 1 | Outgoing serial data |
| mosi_oe | output | 1 | Outgoing data drive enable |
| miso_i | input | 1 | Incoming serial data |
| irq_o | output | 1 | Transmit-drained interrupt |

## Verification
The embedded assertions watch, on every cycle, the structural invariants. FIFO occupancy stays bounded and grows on an accepted lone push. The clock sits at its idle level whenever no frame runs, and a frame ends in the cycle its word is pushed. Halting or soft reset empties the data path, the overflow flag holds until it is cleared, and the half-period counter stays within the divisor. The data-carrying behaviour can only be shown by the bench's scenarios against its cycle-level model. These include the exact placement of every clock transition and data bit for each polarity, phase, order and width, word integrity through loopback and the input pin, dropped writes at FIFO limits, overflow marking, aborted frames and the 65536-cycle half period of a zero divisor.

// File: rtl/spi_host_pkg.sv
// Package: shared constants for the SPI master controller.
// Assumes byte offsets on a 5-bit address and a 16-bit serial word.
package spi_host_pkg;
    localparam int unsigned ADDR_W = 5;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned WORD_W = 16;
    localparam int unsigned DIV_W  = 16;
    localparam int unsigned CTL_W  = 14;

    localparam logic [ADDR_W-1:0] OFS_DIV  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_TXD  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_RXD  = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_CTL  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_MODE = 5'h18;

    localparam int unsigned CB_MSBF = 4;
    localparam int unsigned CB_CPHA = 5;
    localparam int unsigned CB_CPOL = 6;
    localparam int unsigned CB_SRST = 7;
    localparam int unsigned CB_MSTR = 8;
    localparam int unsigned CB_EN   = 9;
    localparam int unsigned CB_LOOP = 10;
    localparam int unsigned CB_TXFE = 11;
    localparam int unsigned CB_RXFE = 12;
    localparam int unsigned IEN_BIT = 2;

    typedef struct packed {
        logic [3:0] width_m1;
        logic       msb_first;
        logic       cpha;
        logic       cpol;
        logic       loopback;
    } frame_cfg_t;
endpackage

// File: rtl/spi_host_fifo.sv
// Module: synchronous word FIFO with flush and a one-entry limit mode.
// Assumes: push to a full FIFO and pop from an empty one are ignored;
// "full" is judged on the occupancy before the clock edge.
module spi_host_fifo #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             single,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = single ? (count != '0) : (count == CNT_W'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (push_ok && !clr) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (pop_ok && !push_ok) count <= count - 1'b1;
        end
    end

    a_r8_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    a_r8_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && !pop_ok && !clr) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/spi_host_baud.sv
// Module: half-period timer for the serial clock.
// Assumes: divisor 0 stands for 2**DIV_W; the counter restarts whenever
// run is low, so the first tick comes a full half period after start.
module spi_host_baud #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim_m1;
    logic             last;

    assign lim_m1 = (divisor == '0) ? {DIV_W{1'b1}} : divisor - 1'b1;
    assign last   = (cnt >= lim_m1);
    assign tick   = run && last;

    // Count system clocks within one half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (last)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $stable(divisor)) |-> (cnt <= lim_m1));
endmodule

// File: rtl/spi_host_shift.sv
// Module: frame engine; loads a word, toggles the clock on each tick,
// shifts data out and assembles the received word.
// Assumes the configuration is held steady while a frame runs.
module spi_host_shift
    import spi_host_pkg::*;
#(
    parameter int unsigned W_MAX = WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             go,
    input  frame_cfg_t       cfg,
    input  logic             tx_avail,
    input  logic [W_MAX-1:0] tx_word,
    input  logic             tick,
    input  logic             miso,
    output logic             tx_pop,
    output logic             busy,
    output logic             sclk,
    output logic             mosi,
    output logic             rx_push,
    output logic [W_MAX-1:0] rx_word
);
    localparam int unsigned IDX_W = $clog2(W_MAX);
    localparam int unsigned WID_W = IDX_W + 1;
    localparam int unsigned EDG_W = IDX_W + 1;

    logic [W_MAX-1:0] word_q, rx_sr;
    logic [IDX_W-1:0] bidx;
    logic [EDG_W-1:0] ecnt;
    logic             phase;
    logic [WID_W-1:0] width;
    logic [WID_W-1:0] oidx_w;
    logic [IDX_W-1:0] oidx;
    logic             last_edge, lead_edge, din;

    assign width     = (cfg.width_m1 == '0) ? WID_W'(2) : WID_W'(cfg.width_m1) + 1'b1;
    assign oidx_w    = cfg.msb_first ? (width - 1'b1 - WID_W'(bidx)) : WID_W'(bidx);
    assign oidx      = oidx_w[IDX_W-1:0];
    assign last_edge = ({1'b0, ecnt} == ({width, 1'b0} - 1'b1));
    assign lead_edge = !ecnt[0];
    assign mosi      = busy && word_q[oidx];
    assign din       = cfg.loopback ? mosi : miso;
    assign sclk      = cfg.cpol ^ phase;
    assign tx_pop    = !busy && go && tx_avail && !clr;
    assign rx_push   = busy && go && !clr && tick && last_edge;

    // Merge the trailing-edge sample taken in the final cycle.
    always_comb begin
        rx_word = rx_sr;
        if (cfg.cpha) rx_word[oidx] = din;
    end

    // Frame sequencing: load, edge stepping, sampling and completion.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !go) begin
            busy  <= 1'b0;
            phase <= 1'b0;
            ecnt  <= '0;
            bidx  <= '0;
            word_q <= '0;
            rx_sr <= '0;
        end else if (tx_pop) begin
            busy   <= 1'b1;
            word_q <= tx_word;
            rx_sr  <= '0;
            bidx   <= '0;
            ecnt   <= '0;
            phase  <= 1'b0;
        end else if (busy && tick) begin
            ecnt  <= ecnt + 1'b1;
            phase <= ~phase;
            if (lead_edge) begin
                if (!cfg.cpha)       rx_sr[oidx] <= din;
                else if (ecnt != '0) bidx <= bidx + 1'b1;
            end else begin
                if (cfg.cpha)        rx_sr[oidx] <= din;
                else if (!last_edge) bidx <= bidx + 1'b1;
            end
            if (last_edge) begin
                busy  <= 1'b0;
                phase <= 1'b0;
            end
        end
    end

    a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cfg.cpol));
    a_r9_push_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> !busy);
endmodule

// File: rtl/spi_host_ctrl.sv
// Module: top of the SPI master controller; register decode, FIFOs,
// timer and frame engine. Assumes single-cycle read and write strobes.
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sclk_o,
    output logic              sclk_oe,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic              irq_o
);
    localparam int unsigned RX_PAD = DATA_W - WORD_W - 2;

    logic [DIV_W-1:0]  div_q;
    logic [CTL_W-1:0]  ctl_q;
    logic              ien_q, ovf_q;
    logic              srst, master, go;
    logic              tx_push, tx_pop, tx_empty, tx_full;
    logic              rx_pop, rx_push, rx_empty, rx_full;
    logic [WORD_W-1:0] tx_head, rx_head, rx_word;
    logic              tick, busy, sclk_i, mosi_i;
    frame_cfg_t        cfg;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:WORD_W];
    assign srst    = ctl_q[CB_SRST];
    assign master  = ctl_q[CB_MSTR];
    assign go      = master && ctl_q[CB_EN];
    assign cfg     = '{width_m1: ctl_q[3:0], msb_first: ctl_q[CB_MSBF],
                       cpha: ctl_q[CB_CPHA], cpol: ctl_q[CB_CPOL],
                       loopback: ctl_q[CB_LOOP]};
    assign tx_push = bus_wr && (bus_addr == OFS_TXD) && !srst;
    assign rx_pop  = bus_rd && (bus_addr == OFS_RXD) && !srst;
    assign sclk_oe = master;
    assign mosi_oe = master;
    assign sclk_o  = master && sclk_i;
    assign mosi_o  = master && mosi_i;
    assign irq_o   = ien_q && tx_empty && !busy;

    // Configuration registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            ctl_q <= '0;
            ien_q <= 1'b0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_DIV: div_q <= bus_wdata[DIV_W-1:0];
                OFS_CTL: ctl_q <= bus_wdata[CTL_W-1:0];
                OFS_IEN: ien_q <= bus_wdata[IEN_BIT];
                default: ;
            endcase
        end
    end

    // Sticky receive-overflow flag, cleared by a receive read.
    always_ff @(posedge clk) begin
        if (!rst_n || srst)         ovf_q <= 1'b0;
        else if (rx_push && rx_full) ovf_q <= 1'b1;
        else if (rx_pop)             ovf_q <= 1'b0;
    end

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_DIV: bus_rdata = DATA_W'(div_q);
            OFS_RXD: bus_rdata = {{RX_PAD{1'b0}}, !rx_empty, ovf_q,
                                  rx_empty ? {WORD_W{1'b0}} : rx_head};
            OFS_CTL: bus_rdata = DATA_W'(ctl_q);
            OFS_IEN: bus_rdata = DATA_W'({ien_q, {IEN_BIT{1'b0}}});
            default: bus_rdata = '0;
        endcase
    end

    spi_host_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(srst), .single(!ctl_q[CB_TXFE]),
        .push(tx_push), .wdata(bus_wdata[WORD_W-1:0]), .pop(tx_pop),
        .rdata(tx_head), .empty(tx_empty), .full(tx_full));

    spi_host_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(srst), .single(!ctl_q[CB_RXFE]),
        .push(rx_push), .wdata(rx_word), .pop(rx_pop),
        .rdata(rx_head), .empty(rx_empty), .full(rx_full));

    spi_host_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(busy), .divisor(div_q), .tick(tick));

    spi_host_shift #(.W_MAX(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(srst), .go(go), .cfg(cfg),
        .tx_avail(!tx_empty), .tx_word(tx_head), .tick(tick), .miso(miso_i),
        .tx_pop(tx_pop), .busy(busy), .sclk(sclk_i), .mosi(mosi_i),
        .rx_push(rx_push), .rx_word(rx_word));

    a_r7_halt_stops: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> !busy);
    a_r11_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (tx_empty && rx_empty && !busy));
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !rx_pop && !srst) |=> ovf_q);
    a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && tx_push && !tx_pop && !srst) |=> !tx_empty);
endmodule

// File: tb/spi_host_ctrl_tb.sv
// Bench: behavioural cycle model (queues and integers) compared with the
// controller on every clock, plus register reads checked against it.
module spi_host_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sclk_o, sclk_oe, mosi_o, mosi_oe, irq_o;
    logic        miso_i = 1'b0;

    int n_chk = 0, n_bad = 0;
    bit cmp_on = 0;

    // model state
    int div_m, ctl_m, ien_m, word_m, k_m;
    bit ovf_m, busy_m;
    int tx_q[$], rx_q[$];
    int w_m, l_m, rxw;
    bit srst_m, go_m, txfull_m, rxfull_m, push_m, txok, rdok;

    always #10 clk = ~clk;

    spi_host_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk_o(sclk_o), .sclk_oe(sclk_oe), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .irq_o(irq_o));

    function automatic int width_of(int c);
        int f = c & 'hF;
        return (f == 0) ? 2 : f + 1;
    endfunction

    function automatic int model_read(int a);
        case (a)
            'h00: return div_m;
            'h08: return (rx_q.size() > 0) ? ((1 << 17) | (int'(ovf_m) << 16) | rx_q[0])
                                           : (int'(ovf_m) << 16);
            'h0C: return ctl_m;
            'h10: return ien_m << 2;
            default: return 0;
        endcase
    endfunction

    // Reference model update on every clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            div_m = 0; ctl_m = 0; ien_m = 0; ovf_m = 0; busy_m = 0; k_m = 0;
            word_m = 0; tx_q.delete(); rx_q.delete();
        end else begin
            srst_m   = ctl_m[7];
            go_m     = ctl_m[8] && ctl_m[9];
            w_m      = width_of(ctl_m);
            l_m      = (div_m == 0) ? 65536 : div_m;
            txfull_m = tx_q.size() >= (ctl_m[11] ? 8 : 1);
            rxfull_m = rx_q.size() >= (ctl_m[12] ? 8 : 1);
            push_m   = 0;
            txok     = bus_wr && bus_addr == 5'h04 && !srst_m && !txfull_m;
            rdok     = bus_rd && bus_addr == 5'h08 && !srst_m;
            if (srst_m || !go_m) busy_m = 0;
            else if (busy_m) begin
                k_m++;
                if (k_m == 2 * w_m * l_m) begin
                    busy_m = 0; push_m = 1;
                    rxw = ctl_m[10] ? (word_m & ((1 << w_m) - 1))
                                    : (miso_i ? ((1 << w_m) - 1) : 0);
                end
            end else if (tx_q.size() > 0) begin
                word_m = tx_q.pop_front(); busy_m = 1; k_m = 0;
            end
            if (txok) tx_q.push_back(int'(bus_wdata[15:0]));
            if (rdok && rx_q.size() > 0) void'(rx_q.pop_front());
            if (srst_m) ovf_m = 0;
            else if (push_m && rxfull_m) ovf_m = 1;
            else if (rdok) ovf_m = 0;
            if (push_m && !rxfull_m && !srst_m) rx_q.push_back(rxw);
            if (srst_m) begin tx_q.delete(); rx_q.delete(); end
            if (bus_wr) begin
                case (bus_addr)
                    5'h00: div_m = int'(bus_wdata[15:0]);
                    5'h0C: ctl_m = int'(bus_wdata[13:0]);
                    5'h10: ien_m = int'(bus_wdata[2]);
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison of pins and interrupt.
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            int t, bi, oi, w;
            bit m;
            m = ctl_m[8];
            w = width_of(ctl_m);
            t = busy_m ? k_m / ((div_m == 0) ? 65536 : div_m) : 0;
            bi = ctl_m[5] ? ((t == 0) ? 0 : (t - 1) / 2) : t / 2;
            oi = ctl_m[4] ? (w - 1 - bi) : bi;
            check("R4", "sclk", int'(sclk_o), m ? int'(ctl_m[6] ^ t[0]) : 0);
            check("R5", "mosi", int'(mosi_o), (m && busy_m) ? ((word_m >> oi) & 1) : 0);
            check("R7", "pin enables", int'({sclk_oe, mosi_oe}), m ? 3 : 0);
            check("R10", "irq", int'(irq_o), int'(ien_m != 0 && tx_q.size() == 0 && !busy_m));
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_addr = 5'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, input string req);
        @(negedge clk);
        bus_addr = 5'(a); bus_rd = 1'b1;
        #2;
        check(req, "read data", int'(bus_rdata), model_read(a));
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1;
        // R1 reset state and register map
        rd('h00, "R1"); rd('h0C, "R1"); rd('h10, "R1"); rd('h08, "R9");
        wr('h00, 3);            rd('h00, "R1");
        wr('h18, 'hFFFF);       rd('h18, "R1");
        wr('h10, 'hFFFF_FFFF);  rd('h10, "R1");
        rd('h04, "R1");
        check("R10", "irq idle", int'(irq_o), 1);
        // R6 loopback, MSB first, 8-bit, mode 0; miso held high
        miso_i = 1'b1;
        wr('h0C, 'h1F17);
        wr('h04, 'h1A5); wr('h04, 'h3C);
        idle(150);
        rd('h08, "R6"); rd('h08, "R2"); rd('h08, "R9");
        // R5 LSB first, 12-bit, cpha=1 cpol=1, divisor 2
        wr('h00, 2); wr('h0C, 'h1F6B);
        wr('h04, 'hABC); wr('h04, 'h123); wr('h04, 'hF0F);
        idle(200);
        rd('h08, "R5"); rd('h08, "R5"); rd('h08, "R2");
        // R6 external input, divisor 1, 16-bit and 5-bit
        wr('h00, 1); wr('h0C, 'h1B4F);
        wr('h04, 'h1234); idle(45);
        rd('h08, "R6");
        miso_i = 1'b0; wr('h0C, 'h1B24);
        wr('h04, 'h1F); idle(25);
        rd('h08, "R6");
        // R8 fill with master off, 9th write dropped
        wr('h0C, 'h1E03);
        for (int i = 1; i <= 9; i++) wr('h04, i);
        idle(5);
        check("R7", "no clock while slave", int'(sclk_oe), 0);
        wr('h0C, 'h1F03);
        idle(100);
        // R9 overflow on a full receive FIFO
        wr('h04, 'h9); idle(20);
        rd('h08, "R9");
        for (int i = 0; i < 8; i++) rd('h08, "R8");
        // R8 single-entry transmit
        wr('h0C, 'h0603);
        wr('h04, 'hA); wr('h04, 'hB);
        wr('h0C, 'h0703); idle(30);
        rd('h08, "R8"); rd('h08, "R8");
        // R9 single-entry receive drops second word
        wr('h0C, 'h0F03);
        wr('h04, 'hC); wr('h04, 'hD); idle(40);
        rd('h08, "R9"); rd('h08, "R9");
        // R7 abort a running frame
        wr('h00, 10); wr('h0C, 'h1F0F);
        wr('h04, 'hBEEF); idle(100);
        wr('h0C, 'h1D0F); idle(10);
        rd('h08, "R7");
        // R11 soft reset
        wr('h0C, 'h1E0F);
        wr('h04, 'h11); wr('h04, 'h22); wr('h04, 'h33);
        wr('h0C, 'h1E8F);
        wr('h04, 'h44);
        rd('h00, "R11"); rd('h0C, "R11");
        wr('h0C, 'h1F0F); idle(20);
        check("R11", "irq after flush", int'(irq_o), 1);
        rd('h08, "R11");
        // R3 zero divisor means 65536
        wr('h00, 0); wr('h0C, 'h1F01);
        wr('h04, 'h2);
        idle(65545);
        check("R3", "first edge after 65536", int'(sclk_o), 1);
        wr('h0C, 'h1F81);
        rd('h08, "R3");
        cmp_on = 0;
        finish_run();
    end
endmodule